// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This controller sits between a simple request port and a dynamic memory whose address pins carry the row and the column one after the other. A user request carries a write flag, a full word address and write data. The controller splits the address into a row part and a column part. It presents the row and latches it with a falling row strobe. It then presents the column and latches it with a falling column strobe. On a read, the data is registered and returned with a single-cycle completion pulse.

The memory loses the contents of a row when it is read, and its cells leak charge. For both reasons the controller always releases the row strobe at the end of an access, which lets the device write the opened row back. A free-running timer raises a refresh request at a fixed interval. At each refresh the controller opens and closes one row without a column strobe (a row-only refresh). A wrapping row counter picks the row, so every row is visited in turn. A refresh that falls due during a user access is taken as soon as that access ends. User requests are held off until the refresh is finished.

Top module: `dramc_top`

## Requirements
- R1: While reset is held and directly after it, both strobes and the write enable are high, the data bus is not driven, `done` is low and `req_ready` is high.
- R2: The row part is `req_addr[ROW_W+COL_W-1:COL_W]` and is on `mem_addr` when `mem_ras_n` falls. The column part is `req_addr[COL_W-1:0]` and is on the same pins when `mem_cas_n` falls.
- R3: `mem_cas_n` falls exactly 2*HOLD_CYC cycles after `mem_ras_n` falls. `mem_addr` is unchanged in the cycle in which either strobe falls, and stays unchanged while `mem_cas_n` is low.
- R4: A write (`req_write`=1) drives `mem_dq_out` with `mem_dq_oe`=1 and `mem_we_n`=0 around the column strobe, and the addressed word takes the new value. A read never drives the bus.
- R5: A read returns the stored word on `rd_data`. `done` is high for exactly one cycle, 3*HOLD_CYC+ACCESS_CYC cycles after the edge that accepts the request.
- R6: `mem_cas_n` is low only while `mem_ras_n` is low, and `mem_ras_n` returns high after every access. Reading the same word twice gives the same value.
- R7: When no user traffic is present, a row-only refresh (row strobe with no column strobe) starts every REF_INTERVAL cycles.
- R8: Successive refreshes use rows that increase by one, and the row number wraps from 2**ROW_W-1 to 0.
- R9: Under back-to-back user requests, refreshes still occur about once per REF_INTERVAL. While a refresh is due, `req_ready` is low.
- R10: Data written once survives an idle period several times longer than the cell retention time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row part in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on an edge where valid and ready are both high |
| rd_data | output | DATA_W | Registered read data |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
If the phase state or its counter is wrong, the effect appears at the pins within one access. The strobe spacing or the done latency moves by whole cycles, or a column strobe is issued outside the row strobe. The assertions catch these on the cycle they happen. A broken address split or multiplexer sends data to the wrong cell, which shows up as a mismatch when that word is read back. Faults in the refresh timer or the row counter stay hidden much longer. They become visible only as wrong refresh spacing or row order in the refresh log, or as charge lost in the bench's memory model after more than one retention period.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RSET,
        PH_RAS,
        PH_CSET,
        PH_CAS,
        PH_PRE
    } phase_e;

    typedef struct packed {
        logic write;
        logic refresh;
    } cmd_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
    parameter int INTERVAL = 64,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int TW = $clog2(INTERVAL);

    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = (tmr == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr     <= '0;
            pending <= 1'b0;
            row     <= '0;
        end else begin
            tmr <= tick ? '0 : tmr + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
            if (ack)
                row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int HOLD   = 2,
    parameter int ACCESS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              ref_pending,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_ack,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase,
    output cmd_t              cmd,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_q,
    output logic              done_q
);
    localparam int CW = $clog2(max_of(HOLD, ACCESS) + 1);

    logic [CW-1:0] cnt;
    logic          last;

    assign last      = (phase == PH_CAS) ? (cnt == CW'(ACCESS - 1))
                                         : (cnt == CW'(HOLD - 1));
    assign req_ready = (phase == PH_IDLE) && !ref_pending;
    assign ref_ack   = (phase == PH_IDLE) && ref_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            cmd     <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase == PH_IDLE) begin
                cnt <= '0;
                if (ref_pending) begin
                    cmd   <= '{write: 1'b0, refresh: 1'b1};
                    row_q <= ref_row;
                    phase <= PH_RSET;
                end else if (req_valid) begin
                    cmd     <= '{write: req_write, refresh: 1'b0};
                    row_q   <= req_row;
                    col_q   <= req_col;
                    wdata_q <= req_wdata;
                    phase   <= PH_RSET;
                end
            end else if (!last) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                unique case (phase)
                    PH_RSET: phase <= PH_RAS;
                    PH_RAS:  phase <= cmd.refresh ? PH_PRE : PH_CSET;
                    PH_CSET: phase <= PH_CAS;
                    PH_CAS: begin
                        phase  <= PH_PRE;
                        done_q <= 1'b1;
                        if (!cmd.write)
                            rd_q <= dq_in;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dramc_pins.sv
module dramc_pins
    import dramc_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int MA_W  = 4
) (
    input  phase_e            phase,
    input  cmd_t              cmd,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    output logic [MA_W-1:0]   mem_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dq_oe
);
    logic col_phase;
    logic wr_drive;

    assign col_phase = (phase == PH_CSET) || (phase == PH_CAS);
    assign wr_drive  = col_phase && cmd.write && !cmd.refresh;

    always_comb begin
        mem_addr = col_phase ? MA_W'(col_q) : MA_W'(row_q);
        ras_n    = !((phase == PH_RAS) || col_phase);
        cas_n    = !(phase == PH_CAS);
        we_n     = !wr_drive;
        dq_oe    = wr_drive;
    end
endmodule

// File: rtl/dramc_top.sv
module dramc_top
    import dramc_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int HOLD_CYC     = 2,
    parameter int ACCESS_CYC   = 2,
    parameter int REF_INTERVAL = 64,
    localparam int AW          = ROW_W + COL_W,
    localparam int MA_W        = max_of(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    phase_e            phase;
    cmd_t              cmd;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              ref_pending;
    logic              ref_ack;
    logic [ROW_W-1:0]  ref_row;

    dramc_ref_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    dramc_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .HOLD(HOLD_CYC), .ACCESS(ACCESS_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_row     (req_addr[AW-1:COL_W]),
        .req_col     (req_addr[COL_W-1:0]),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .ref_ack     (ref_ack),
        .dq_in       (mem_dq_in),
        .phase       (phase),
        .cmd         (cmd),
        .row_q       (row_q),
        .col_q       (col_q),
        .wdata_q     (mem_dq_out),
        .rd_q        (rd_data),
        .done_q      (done)
    );

    dramc_pins #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_pins (
        .phase    (phase),
        .cmd      (cmd),
        .row_q    (row_q),
        .col_q    (col_q),
        .mem_addr (mem_addr),
        .ras_n    (mem_ras_n),
        .cas_n    (mem_cas_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe)
    );
endmodule

// File: rtl/dramc_chk.sv
module dramc_chk #(
    parameter int MA_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [MA_W-1:0] mem_addr,
    input logic            mem_ras_n,
    input logic            mem_cas_n,
    input logic            mem_we_n,
    input logic            mem_dq_oe,
    input logic            done
);
    assert_cas_inside_ras_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> !mem_ras_n);

    assert_addr_at_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_ras_n) || $fell(mem_cas_n)) |-> $stable(mem_addr));

    assert_addr_during_cas_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |=> (mem_cas_n || $stable(mem_addr)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_ras_n));
endmodule

bind dramc_top dramc_chk #(.MA_W(MA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .done      (done)
);

// File: tb/tb_dramc_top.sv
module tb_dramc_top;
    localparam int ROW_W = 4, COL_W = 4, DW = 8, HOLD = 2, ACC = 2, RINT = 64;
    localparam int NROW = 1 << ROW_W, NCOL = 1 << COL_W;
    localparam int RET  = 1200;
    localparam int LAT  = 3 * HOLD + ACC;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [7:0] req_addr = 0;
    logic [DW-1:0] req_wdata = 0;
    logic req_ready, done, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic [3:0] mem_addr;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dramc_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .HOLD_CYC(HOLD),
                .ACCESS_CYC(ACC), .REF_INTERVAL(RINT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .done(done), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    // memory model: destructive row read, restore on row strobe release, charge decay
    logic [DW-1:0] arr [NROW][NCOL];
    logic [DW-1:0] rowbuf [NCOL];
    bit   rvalid [NROW];
    int   lastr [NROW];
    int   open_row = 0, ras_fall_cyc = 0, cas_gap = 0, lost_cnt = 0;
    int   seen_row = 0, seen_col = 0;
    bit   saw_cas = 0, prev_ras = 1, prev_cas = 1;
    int   ref_n = 0;
    int   ref_row_log [512];
    int   ref_cyc_log [512];

    assign mem_dq_in = (!mem_cas_n && mem_we_n) ? rowbuf[mem_addr] : '0;

    initial begin
        for (int r = 0; r < NROW; r++) begin
            rvalid[r] = 1; lastr[r] = 0;
            for (int c = 0; c < NCOL; c++) arr[r][c] = '0;
        end
        for (int c = 0; c < NCOL; c++) rowbuf[c] = '0;
    end

    always @(posedge clk) begin
        prev_ras <= mem_ras_n;
        prev_cas <= mem_cas_n;
        if (!rst) begin
            if (prev_ras && !mem_ras_n) begin
                open_row = mem_addr;
                if (!rvalid[open_row] || (cyc - lastr[open_row]) > RET) lost_cnt++;
                for (int c = 0; c < NCOL; c++) rowbuf[c] = arr[open_row][c];
                rvalid[open_row] = 0;
                saw_cas = 0;
                ras_fall_cyc = cyc;
            end
            if (prev_cas && !mem_cas_n) begin
                saw_cas = 1;
                seen_row = open_row;
                seen_col = mem_addr;
                cas_gap = cyc - ras_fall_cyc;
                if (!mem_we_n) rowbuf[mem_addr] = mem_dq_out;
            end
            if (!prev_ras && mem_ras_n) begin
                for (int c = 0; c < NCOL; c++) arr[open_row][c] = rowbuf[c];
                rvalid[open_row] = 1;
                lastr[open_row] = cyc;
                if (!saw_cas && ref_n < 512) begin
                    ref_row_log[ref_n] = open_row;
                    ref_cyc_log[ref_n] = ras_fall_cyc;
                    ref_n++;
                end
            end
        end
    end

    logic [DW-1:0] exp_mem [256];
    initial for (int i = 0; i < 256; i++) exp_mem[i] = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output bit oe_seen);
        int c0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        c0 = cyc;
        oe_seen = 0;
        @(negedge clk);
        req_valid = 0;
        while (!done) begin
            if (mem_dq_oe) oe_seen = 1;
            @(negedge clk);
        end
        lat = cyc - c0 - 1;
        rd = rd_data;
        @(negedge clk);
        check(!done, "R5 done width", done, 0);
        if (wr) exp_mem[a] = wd;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
              {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst = 0;
        @(negedge clk);
        check(!done && req_ready && mem_ras_n && mem_cas_n, "R1 after reset",
              {done, req_ready, mem_ras_n, mem_cas_n}, 4'b0111);
    endtask

    task automatic t_rw();
        logic [7:0] addrs [6] = '{8'h00, 8'hff, 8'h5a, 8'ha5, 8'h3c, 8'h37};
        logic [7:0] vals  [6] = '{8'h11, 8'hee, 8'hc3, 8'h3c, 8'h80, 8'h01};
        logic [DW-1:0] rd; int lat; bit oe;
        for (int i = 0; i < 6; i++) begin
            access(1, addrs[i], vals[i], rd, lat, oe);
            check(oe, "R4 write drives bus", oe, 1);
            check(seen_row == addrs[i][7:4] && seen_col == addrs[i][3:0],
                  "R2 write row/col", {seen_row[3:0], seen_col[3:0]}, addrs[i]);
            check(cas_gap == 2 * HOLD, "R3 strobe spacing", cas_gap, 2 * HOLD);
        end
        for (int i = 0; i < 6; i++) begin
            access(0, addrs[i], 0, rd, lat, oe);
            check(rd == vals[i], "R5 read data", rd, vals[i]);
            check(lat == LAT, "R5 latency", lat, LAT);
            check(!oe, "R4 read leaves bus undriven", oe, 0);
            check(seen_row == addrs[i][7:4] && seen_col == addrs[i][3:0],
                  "R2 read row/col", {seen_row[3:0], seen_col[3:0]}, addrs[i]);
            access(0, addrs[i], 0, rd, lat, oe);
            check(rd == vals[i], "R6 repeated read", rd, vals[i]);
        end
        check(lost_cnt == 0, "R6 rows restored", lost_cnt, 0);
    endtask

    task automatic t_refresh_idle();
        int s, wraps;
        s = ref_n;
        wraps = 0;
        repeat (NROW * RINT + 200) @(negedge clk);
        check(ref_n - s >= NROW + 2, "R7 refresh count idle", ref_n - s, NROW + 2);
        for (int i = s + 2; i < ref_n; i++) begin
            check(ref_cyc_log[i] - ref_cyc_log[i-1] == RINT, "R7 refresh spacing",
                  ref_cyc_log[i] - ref_cyc_log[i-1], RINT);
            check(ref_row_log[i] == (ref_row_log[i-1] + 1) % NROW, "R8 refresh row order",
                  ref_row_log[i], (ref_row_log[i-1] + 1) % NROW);
            if (ref_row_log[i] == 0) wraps++;
        end
        check(wraps >= 1, "R8 row counter wrap", wraps, 1);
    endtask

    task automatic t_traffic();
        int s, c0, minref;
        logic [DW-1:0] rd; int lat; bit oe;
        logic [7:0] a;
        s = ref_n; c0 = cyc;
        for (int i = 0; i < 60; i++) begin
            a = (i % 2) ? 8'h5a : 8'h3c;
            access(0, a, 0, rd, lat, oe);
            check(rd == exp_mem[a], "R9 read under refresh load", rd, exp_mem[a]);
        end
        minref = (cyc - c0) / RINT - 1;
        check(ref_n - s >= minref, "R9 refresh interleaved", ref_n - s, minref);
    endtask

    task automatic t_retention();
        logic [7:0] addrs [4] = '{8'h00, 8'hff, 8'ha5, 8'h37};
        logic [DW-1:0] rd; int lat; bit oe;
        repeat (3 * RET) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            access(0, addrs[i], 0, rd, lat, oe);
            check(rd == exp_mem[addrs[i]], "R10 data after long idle", rd, exp_mem[addrs[i]]);
        end
        check(lost_cnt == 0, "R10 no charge lost", lost_cnt, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_rw();
        t_refresh_idle();
        t_traffic();
        t_retention();
        finish_run();
    end
endmodule